// File: doc/BRIEF.md
# Embedded-Clock Deserializer with False-Lock Guard

The block receives a recovered serial stream, one bit per cycle in which `bit_en` is high. The stream carries 12-bit frames. Each frame is a clock-high bit of value 1, ten payload bits, and a clock-low bit of value 0. The block watches all twelve possible frame alignments at once and discards any alignment at which the 1-then-0 clock pair fails. It locks when exactly one alignment has survived long enough. Once locked, it delivers each payload word on a parallel bus with a one-cycle strobe, a half-frame word clock and an active-low lock flag.

Lock needs no help from the transmitter. It can be reached from a sync pattern or from ordinary random traffic. A repetitive payload that contains a 0-to-1 step makes a second alignment look as valid as the real one. While that pattern lasts, the block withholds lock, and it locks only after the data changes.

A receiver-enable input gates the externally visible outputs; it stands in for tri-state pads. Holding that enable and the active-low power input both low at the same time is the powerdown condition. Powerdown clears all search and lock state.

Top module: `emb_deser`

## Requirements
- R1: Reset state (synchronous, `rst_n` low), with `rx_en` high:
  - `lock_n` is 1.
  - `word_vld`, `word_stb`, `wclk_out` and `word_out` are all 0.
- R2: Alignment candidates:
  - On each `bit_en`, the candidate for the current phase (a 12-step counter) is tested. It passes if the bit received 11 slots earlier is 1 and the newest bit is 0.
  - A failing candidate is removed.
  - When no candidate remains, all 12 are re-armed.
  - No candidate is tested until 12 bits have arrived since reset or powerdown.
- R3: Lock acquisition:
  - `lock_n` falls one cycle after the `bit_en` at which a sole remaining candidate passes for the LOCK_FRAMES-th consecutive time (default 64).
  - The run count restarts whenever more or fewer than one candidate remains.
- R4: Lock is reached from random payload data without any sync pattern.
- R5: Word output and strobe:
  - For every accepted frame, `word_stb` pulses high for one cycle, one cycle after the clock-low bit's `bit_en`. The locking frame counts as accepted.
  - `word_out[i]` is the (i+1)-th bit received after the clock-high bit, so bit 0 is the first payload bit.
- R6: While two alignments keep passing, lock is never asserted. Example: payload bits 0..3 are 0 and bits 4..9 are 1, repeated.
- R7: Lock loss:
  - While locked, DROP_N consecutive failing frames at the locked alignment (default 4) raise `lock_n` one cycle after the last one, and the search restarts with all candidates armed.
  - A passing frame resets the failure count.
- R8: While `lock_n` is 1, `word_vld`, `word_out` and `wclk_out` are 0.
- R9: Word clock (`wclk_out`):
  - An internal level goes high with each strobe and falls at the 6th later `bit_en`. It is also cleared when lock is lost.
  - When `word_vld` is 1, `wclk_out` equals that level if `edge_rise` is 1, and its inverse if `edge_rise` is 0.
- R10: `rx_en` at 0:
  - `lock_n` reads 1, and `word_vld`, `word_stb`, `word_out` and `wclk_out` read 0.
  - The lock state is kept and shows again once `rx_en` returns to 1.
- R11: Powerdown:
  - `pwr_n` at 0 together with `rx_en` at 0 clears all state, so a complete new search is needed afterwards.
  - `pwr_n` at 0 alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Serial bit qualifier |
| ser_in | input | 1 | Serial data bit |
| rx_en | input | 1 | Output enable, active high |
| pwr_n | input | 1 | Power control; low with rx_en low enters powerdown |
| edge_rise | input | 1 | 1: word clock rises with new data, 0: falls |
| word_out | output | PAYLOAD_W | Recovered payload word |
| word_vld | output | 1 | Outputs valid (stands in for driven pads) |
| word_stb | output | 1 | One-cycle pulse per recovered word |
| wclk_out | output | 1 | Recovered word clock |
| lock_n | output | 1 | Lock flag, active low |

## Verification
The hardest state to reach is the ambiguous one. It needs a fresh candidate mask, and then a repetitive pattern that keeps two alignments alive indefinitely. A stale mask would already have pruned the second alignment during earlier random traffic. The bench therefore enters powerdown, resumes at a new bit offset, and streams 200 frames of the two-transition payload. It then switches to random payload and expects lock to follow. The lock-loss path is reached by corrupting the clock-high bit for one frame fewer than the drop count, sending one good frame, and then sending the full count of bad frames.

// File: rtl/emb_deser.sv
module emb_deser #(
  parameter int PAYLOAD_W   = 10,
  parameter int LOCK_FRAMES = 64,
  parameter int DROP_N      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 ser_in,
  input  logic                 rx_en,
  input  logic                 pwr_n,
  input  logic                 edge_rise,
  output logic [PAYLOAD_W-1:0] word_out,
  output logic                 word_vld,
  output logic                 word_stb,
  output logic                 wclk_out,
  output logic                 lock_n
);
  localparam int FRAME_W = PAYLOAD_W + 2;
  localparam int PH_W    = $clog2(FRAME_W);
  localparam int RUN_W   = $clog2(LOCK_FRAMES + 1);
  localparam int MISS_W  = $clog2(DROP_N + 1);
  localparam int HALF    = FRAME_W / 2;
  localparam int HC_W    = $clog2(HALF + 1);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(FRAME_W - 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(LOCK_FRAMES - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(DROP_N - 1);
  localparam logic [HC_W-1:0]   HC_LAST   = HC_W'(HALF - 1);

  logic [FRAME_W-1:0]   hist, hist_nx, cand, cand_clr, cand_nx, ph_oh;
  logic [PH_W-1:0]      ph, lock_ph;
  logic [RUN_W-1:0]     run;
  logic [MISS_W-1:0]    miss;
  logic [HC_W-1:0]      hcnt;
  logic [PAYLOAD_W-1:0] word_q, word_nx;
  logic locked, stb_q, wlev, primed;
  logic pd, ok, judge, sole, hit, at_lock, lock_now, accept, drop;

  assign pd      = ~pwr_n & ~rx_en;
  assign hist_nx = {hist[FRAME_W-2:0], ser_in};
  assign ok      = hist_nx[FRAME_W-1] & ~hist_nx[0];
  assign judge   = primed | (ph == PH_LAST);

  for (genvar k = 0; k < FRAME_W; k++) begin : g_slot
    assign ph_oh[k]    = (ph == PH_W'(k));
    assign cand_clr[k] = cand[k] & (ok | ~judge | ~ph_oh[k]);
  end

  for (genvar k = 0; k < PAYLOAD_W; k++) begin : g_pay
    assign word_nx[k] = hist_nx[FRAME_W-2-k];
  end

  assign cand_nx  = (cand_clr == '0) ? '1 : cand_clr;
  assign sole     = ($countones(cand_nx) == 1);
  assign hit      = |(cand_nx & ph_oh);
  assign at_lock  = locked & (ph == lock_ph);
  assign lock_now = bit_en & ~locked & sole & hit & (run == RUN_LAST);
  assign accept   = lock_now | (bit_en & at_lock & ok);
  assign drop     = bit_en & at_lock & ~ok & (miss == MISS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || pd) begin
      hist    <= '0;
      cand    <= '1;
      ph      <= '0;
      lock_ph <= '0;
      run     <= '0;
      miss    <= '0;
      hcnt    <= '0;
      word_q  <= '0;
      locked  <= 1'b0;
      stb_q   <= 1'b0;
      wlev    <= 1'b0;
      primed  <= 1'b0;
    end else begin
      stb_q <= accept;
      if (bit_en) begin
        hist <= hist_nx;
        ph   <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        if (ph == PH_LAST) primed <= 1'b1;
        if (!locked) begin
          cand <= cand_nx;
          if (!sole) run <= '0;
          else if (hit) run <= run + 1'b1;
          if (lock_now) begin
            locked  <= 1'b1;
            lock_ph <= ph;
          end
        end else if (at_lock) begin
          if (ok) miss <= '0;
          else if (drop) begin
            locked <= 1'b0;
            miss   <= '0;
            run    <= '0;
            cand   <= '1;
          end else miss <= miss + 1'b1;
        end
        if (accept) word_q <= word_nx;
        if (drop) begin
          wlev <= 1'b0;
          hcnt <= '0;
        end else if (accept) begin
          wlev <= 1'b1;
          hcnt <= '0;
        end else if (wlev) begin
          if (hcnt == HC_LAST) wlev <= 1'b0;
          else hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  assign word_vld = rx_en & locked;
  assign lock_n   = ~(rx_en & locked);
  assign word_out = word_vld ? word_q : '0;
  assign word_stb = stb_q & rx_en;
  assign wclk_out = word_vld & (wlev ~^ edge_rise);
endmodule

// File: rtl/emb_deser_chk.sv
module emb_deser_chk #(
  parameter int FW = 12,
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          rx_en,
  input logic          pwr_n,
  input logic          lock_n,
  input logic          word_vld,
  input logic          word_stb,
  input logic          wclk_out,
  input logic [PW-1:0] word_out,
  input logic          locked,
  input logic [FW-1:0] cand
);
  // R5
  stb_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> !lock_n);
  // R5
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);
  // R10
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (lock_n && !word_vld && !word_stb && !wclk_out));
  // R11
  pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_n && !rx_en) |=> !locked);
  // R6
  sole_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> ($countones(cand) == 1));
  // R3
  lock_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(bit_en));
  // R2
  cand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && pwr_n) |=> $stable(cand));
  // R8
  unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_n |-> (word_out == '0 && !wclk_out && !word_vld));
endmodule

bind emb_deser emb_deser_chk #(.FW(FRAME_W), .PW(PAYLOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_en(rx_en), .pwr_n(pwr_n),
  .lock_n(lock_n), .word_vld(word_vld), .word_stb(word_stb),
  .wclk_out(wclk_out), .word_out(word_out), .locked(locked), .cand(cand)
);

// File: tb/test_emb_deser.sv
module test_emb_deser;
  localparam int CLK_PERIOD = 10;
  localparam int LF = 64;
  localparam int DN = 4;

  logic clk = 1'b0;
  logic rst_n, bit_en, ser_in, rx_en, pwr_n, edge_rise;
  logic [9:0] word_out;
  logic word_vld, word_stb, wclk_out, lock_n;

  int vecs = 0, fails = 0, cyc = 0, gap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emb_deser #(.PAYLOAD_W(10), .LOCK_FRAMES(LF), .DROP_N(DN)) i_emb_deser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .rx_en(rx_en),
    .pwr_n(pwr_n), .edge_rise(edge_rise), .word_out(word_out), .word_vld(word_vld),
    .word_stb(word_stb), .wclk_out(wclk_out), .lock_n(lock_n));

  // behavioural reference
  int m_hist[$];
  bit m_cand[12];
  int m_ph, m_lp, m_run, m_miss, m_cnt, m_fill, m_word;
  bit m_lock, m_stb, m_lev;

  task automatic m_clear();
    m_hist = {};
    for (int k = 0; k < 12; k++) begin m_hist.push_back(0); m_cand[k] = 1; end
    m_ph = 0; m_lp = 0; m_run = 0; m_miss = 0; m_cnt = 0; m_fill = 0; m_word = 0;
    m_lock = 0; m_stb = 0; m_lev = 0;
  endtask

  always @(posedge clk) begin
    bit good, acc, drp;
    int n;
    if (!rst_n || (!pwr_n && !rx_en)) m_clear();
    else begin
      m_stb = 0;
      if (bit_en) begin
        acc = 0; drp = 0;
        m_hist.push_back(int'(ser_in));
        void'(m_hist.pop_front());
        m_fill++;
        good = (m_hist[0] == 1) && (m_hist[11] == 0);
        if (!m_lock) begin
          if (!good && m_fill >= 12) m_cand[m_ph] = 0;
          n = 0;
          for (int k = 0; k < 12; k++) n += int'(m_cand[k]);
          if (n == 0) begin
            for (int k = 0; k < 12; k++) m_cand[k] = 1;
            n = 12;
          end
          if (n != 1) m_run = 0;
          else if (m_cand[m_ph]) begin
            m_run++;
            if (m_run == LF) begin m_lock = 1; m_lp = m_ph; acc = 1; end
          end
        end else if (m_ph == m_lp) begin
          if (good) begin m_miss = 0; acc = 1; end
          else begin
            m_miss++;
            if (m_miss == DN) begin
              drp = 1; m_lock = 0; m_miss = 0; m_run = 0;
              for (int k = 0; k < 12; k++) m_cand[k] = 1;
            end
          end
        end
        if (acc) begin
          m_word = 0;
          for (int i = 0; i < 10; i++) if (m_hist[1+i] == 1) m_word |= (1 << i);
        end
        if (drp) begin m_lev = 0; m_cnt = 0; end
        else if (acc) begin m_lev = 1; m_cnt = 0; end
        else if (m_lev) begin
          if (m_cnt == 5) m_lev = 0; else m_cnt++;
        end
        m_stb = acc;
        m_ph = (m_ph + 1) % 12;
      end
    end
  end

  task automatic expect_eq(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit ev;
    ev = rx_en && m_lock;
    expect_eq(rx_en ? "R3 lock_n" : "R10 lock_n", int'(lock_n), int'(!ev));
    expect_eq(rx_en ? "R8 word_vld" : "R10 word_vld", int'(word_vld), int'(ev));
    expect_eq(rx_en ? "R5 word_out" : "R10 word_out", int'(word_out), ev ? m_word : 0);
    expect_eq(rx_en ? "R5 word_stb" : "R10 word_stb", int'(word_stb), int'(rx_en && m_stb));
    expect_eq(rx_en ? "R9 wclk_out" : "R10 wclk_out", int'(wclk_out),
              int'(ev && (edge_rise ? m_lev : !m_lev)));
  endtask

  task automatic tick(input logic be, input logic b);
    @(negedge clk);
    compare();
    bit_en = be;
    ser_in = b;
  endtask

  task automatic send_bit(input logic b);
    gap++;
    if (gap % 4 == 0) tick(1'b0, 1'b0);
    tick(1'b1, b);
  endtask

  task automatic send_frame(input logic c1, input logic [9:0] pay, input logic c0);
    send_bit(c1);
    for (int i = 0; i < 10; i++) send_bit(pay[i]);
    send_bit(c0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic power_cycle();
    tick(1'b0, 1'b0);
    rx_en = 1'b0; pwr_n = 1'b0;
    idle(3);
    rx_en = 1'b1; pwr_n = 1'b1;
    idle(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; ser_in = 1'b0;
    rx_en = 1'b1; pwr_n = 1'b1; edge_rise = 1'b1;
    m_clear();
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    expect_eq("R1 lock_n", int'(lock_n), 1);
    expect_eq("R1 word_vld", int'(word_vld), 0);
    expect_eq("R1 word_stb", int'(word_stb), 0);
    expect_eq("R1 word_out", int'(word_out), 0);
    expect_eq("R1 wclk_out", int'(wclk_out), 0);

    // R2 R3: sync pattern at an odd bit offset
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    for (int i = 0; i < 100; i++) send_frame(1'b1, 10'h01F, 1'b0);
    idle(1);
    expect_eq("R3 locked on sync", int'(lock_n), 0);

    // R5 R9: random payload with both word clock polarities
    for (int i = 0; i < 40; i++) begin
      if (i == 20) edge_rise = 1'b0;
      send_frame(1'b1, 10'($urandom), 1'b0);
    end
    idle(1);
    expect_eq("R5 last word", int'(word_out), m_word);
    edge_rise = 1'b1;

    // R7: one short of the drop count, then a good frame, then the full count
    for (int i = 0; i < DN - 1; i++) send_frame(1'b0, 10'($urandom), 1'b0);
    idle(1);
    expect_eq("R7 lock held", int'(lock_n), 0);
    send_frame(1'b1, 10'h2A5, 1'b0);
    for (int i = 0; i < DN - 1; i++) send_frame(1'b0, 10'($urandom), 1'b0);
    idle(1);
    expect_eq("R7 miss count reset", int'(lock_n), 0);
    send_frame(1'b0, 10'h155, 1'b0);
    idle(1);
    expect_eq("R7 lock lost", int'(lock_n), 1);

    // R4: relock on random data
    for (int i = 0; i < 150; i++) send_frame(1'b1, 10'($urandom), 1'b0);
    idle(1);
    expect_eq("R4 random lock", int'(lock_n), 0);

    // R10: receiver disabled keeps state
    rx_en = 1'b0;
    for (int i = 0; i < 3; i++) send_frame(1'b1, 10'($urandom), 1'b0);
    idle(1);
    expect_eq("R10 lock_n hidden", int'(lock_n), 1);
    expect_eq("R10 word_vld", int'(word_vld), 0);
    rx_en = 1'b1;
    idle(1);
    expect_eq("R10 lock kept", int'(lock_n), 0);

    // R11: pwr_n alone does nothing
    pwr_n = 1'b0;
    idle(3);
    pwr_n = 1'b1;
    idle(1);
    expect_eq("R11 pwr_n alone", int'(lock_n), 0);

    // R11: powerdown forces a full new search
    power_cycle();
    expect_eq("R11 unlocked after powerdown", int'(lock_n), 1);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    for (int i = 0; i < 30; i++) send_frame(1'b1, 10'($urandom), 1'b0);
    idle(1);
    expect_eq("R11 no early lock", int'(lock_n), 1);

    // R6: repetitive two-transition payload never locks
    power_cycle();
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    for (int i = 0; i < 200; i++) send_frame(1'b1, 10'h3F0, 1'b0);
    idle(1);
    expect_eq("R6 no false lock", int'(lock_n), 1);
    for (int i = 0; i < 200; i++) send_frame(1'b1, 10'($urandom), 1'b0);
    idle(1);
    expect_eq("R6 lock after pattern change", int'(lock_n), 0);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule